// File: doc/BRIEF.md
# Masked Level Interrupt Controller

This block collects up to 32 level-sensitive interrupt sources into one request line for a processor core. Each source that is seen high latches a pending bit in a status register. A software-programmed enable register selects which pending bits may raise the request. The request is high whenever a pending bit is also enabled. Software dismisses a serviced source by writing a one to its position in the status register.

Both registers sit on the core's special-register access bus. The address is split into a group number in the upper bits and an index in the lower bits. The controller answers only to its own two addresses. Reads are combinational in the access cycle. Writes take effect at the next rising clock edge. The request output is a register, and it is updated at the same edge as the enable and pending registers.

Top module: `irq_mask_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the enable register and the pending register both read zero and `irq_o` is low.
- R2: The enable register sits at address group 9, index 0. The address is `acc_addr[15:11]` = group and `acc_addr[10:0]` = index, so the enable register is at 0x4800. A write stores `acc_wdata` at the next edge, and a read returns the stored value.
- R3: The pending register sits at group 9, index 2 (0x4802) and can be read. A source that is high at a clock edge sets its pending bit, and the bit stays set after the source falls.
- R4: A write to 0x4802 clears every pending bit whose `acc_wdata` bit is 1 and leaves the other pending bits unchanged. Writing zero has no effect.
- R5: If a source is high in the same cycle that a write clears its pending bit, the bit stays set.
- R6: `irq_o` is high exactly when the AND of pending and enable is nonzero. After a write to either register or a new pending bit, `irq_o` reflects the new value from the next cycle on.
- R7: A write to any address other than 0x4800 or 0x4802 changes neither register. A read of such an address returns zero.
- R8: `acc_rdata` is zero unless `acc_en` is high and `acc_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level interrupt sources |
| acc_en | input | 1 | Register access valid this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | Group (15:11) and index (10:0) |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The bench walks every source bit through set, hold and clear. A design with the clear polarity reversed, or one that overwrites the status with the write data, leaves the wrong bits pending. It clears a bit while its source is still high. A design that lets the clear win drops a live interrupt. It sweeps every enable bit against single pending bits and checks the request one cycle after each write. A stale or inverted request shows up immediately. Writes to the neighbouring index and to other groups catch a decoder that ignores the group field or the low index bits.

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int NSRC      = 32,
  parameter int AW        = 16,
  parameter int GRP_LSB   = 11,
  parameter int GROUP     = 9,
  parameter int EN_IDX    = 0,
  parameter int PEND_IDX  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            acc_en,
  input  logic            acc_we,
  input  logic [AW-1:0]   acc_addr,
  input  logic [NSRC-1:0] acc_wdata,
  output logic [NSRC-1:0] acc_rdata,
  output logic            irq_o
);

  localparam logic [AW-1:0] EN_ADDR   = AW'((GROUP << GRP_LSB) | EN_IDX);
  localparam logic [AW-1:0] PEND_ADDR = AW'((GROUP << GRP_LSB) | PEND_IDX);

  logic [NSRC-1:0] mask_q, stat_q, mask_d, stat_d;
  logic            wr, rd, hit_en, hit_pend;

  assign wr       = acc_en & acc_we;
  assign rd       = acc_en & ~acc_we;
  assign hit_en   = acc_addr == EN_ADDR;
  assign hit_pend = acc_addr == PEND_ADDR;

  assign mask_d = (wr && hit_en) ? acc_wdata : mask_q;
  assign stat_d = ((wr && hit_pend) ? (stat_q & ~acc_wdata) : stat_q) | src_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      stat_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      stat_q <= stat_d;
      irq_o  <= |(mask_d & stat_d);
    end
  end

  always_comb begin
    acc_rdata = '0;
    if (rd && hit_en)   acc_rdata = mask_q;
    if (rd && hit_pend) acc_rdata = stat_q;
  end

endmodule

module irq_mask_ctrl_chk #(
  parameter int NSRC = 32,
  parameter int AW   = 16,
  parameter logic [AW-1:0] EN_ADDR   = 16'h4800,
  parameter logic [AW-1:0] PEND_ADDR = 16'h4802
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_i,
  input logic            acc_en,
  input logic            acc_we,
  input logic [AW-1:0]   acc_addr,
  input logic [NSRC-1:0] acc_wdata,
  input logic [NSRC-1:0] acc_rdata,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] stat_q,
  input logic            irq_o
);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (mask_q == '0 && stat_q == '0 && !irq_o));

  a_r2_mask_store: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_we && acc_addr == EN_ADDR) |=> mask_q == $past(acc_wdata));

  a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && acc_we && acc_addr == EN_ADDR) |=> $stable(mask_q));

  a_r3_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && acc_we && acc_addr == PEND_ADDR)
      |=> stat_q == ($past(stat_q) | $past(src_i)));

  a_r4_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_we && acc_addr == PEND_ADDR)
      |=> stat_q == (($past(stat_q) & ~$past(acc_wdata)) | $past(src_i)));

  a_r6_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|(stat_q & mask_q)));

  a_r8_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_we) |-> acc_rdata == '0);

endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(
  .NSRC(NSRC), .AW(AW), .EN_ADDR(EN_ADDR), .PEND_ADDR(PEND_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .acc_en(acc_en), .acc_we(acc_we),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
  .mask_q(mask_q), .stat_q(stat_q), .irq_o(irq_o)
);

// File: tb/irq_mask_ctrl_tb.sv
`timescale 1ns/1ps
module irq_mask_ctrl_tb;
  localparam logic [15:0] EN_A = 16'h4800;
  localparam logic [15:0] PD_A = 16'h4802;

  logic        clk = 0, rst_n = 0;
  logic [31:0] src_i = '0, acc_wdata = '0, acc_rdata;
  logic        acc_en = 0, acc_we = 0, irq_o;
  logic [15:0] acc_addr = '0;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  irq_mask_ctrl u_dut (.clk(clk), .rst_n(rst_n), .src_i(src_i), .acc_en(acc_en),
    .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .irq_o(irq_o));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    acc_en = 1; acc_we = 1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_we = 0; acc_wdata = '0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    acc_en = 1; acc_we = 0; acc_addr = a;
    #1 d = acc_rdata;
    acc_en = 0;
  endtask

  task automatic pulse(logic [31:0] s);
    @(negedge clk); src_i = s;
    @(negedge clk); src_i = '0;
  endtask

  logic [31:0] v;

  initial begin
    #20;
    check("R1 irq in reset", {31'b0, irq_o}, 0);
    @(negedge clk); rst_n = 1;
    #1 check("R1 irq after reset", {31'b0, irq_o}, 0);
    rd(EN_A, v); check("R1 enable reset", v, 0);
    rd(PD_A, v); check("R1 pending reset", v, 0);

    for (int i = 0; i < 32; i++) begin
      wr(EN_A, 32'h1 << i); rd(EN_A, v); check("R2 enable walk", v, 32'h1 << i);
    end
    wr(EN_A, 32'hDEAD_BEEF); rd(EN_A, v); check("R2 enable pattern", v, 32'hDEAD_BEEF);
    wr(EN_A, 0);

    for (int i = 0; i < 32; i++) begin
      pulse(32'h1 << i);
      rd(PD_A, v); check("R3 sticky set", v, 32'h1 << i);
      wr(PD_A, 32'h1 << i);
      rd(PD_A, v); check("R4 single clear", v, 0);
    end

    pulse(32'hFFFF_FFFF);
    wr(PD_A, 32'hA5A5_0F0F); rd(PD_A, v); check("R4 pattern clear", v, 32'h5A5A_F0F0);
    wr(PD_A, 0); rd(PD_A, v); check("R4 zero write", v, 32'h5A5A_F0F0);
    wr(PD_A, 32'hFFFF_FFFF); rd(PD_A, v); check("R4 clear all", v, 0);

    pulse(32'h18);
    @(negedge clk); src_i = 32'h8;
    wr(PD_A, 32'h18);
    src_i = 0;
    rd(PD_A, v); check("R5 set wins", v, 32'h8);
    wr(PD_A, 32'h8);

    for (int i = 0; i < 32; i++) begin
      pulse(32'h1 << ((i * 7) % 32));
      for (int j = 0; j < 32; j++) begin
        wr(EN_A, 32'h1 << j);
        check("R6 irq after enable write", {31'b0, irq_o}, {31'b0, (i * 7) % 32 == j});
      end
      wr(EN_A, 32'h1 << ((i * 7) % 32));
      wr(PD_A, 32'hFFFF_FFFF);
      check("R6 irq after clear", {31'b0, irq_o}, 0);
    end
    wr(EN_A, 32'h100);
    pulse(32'h100);
    check("R6 irq from source", {31'b0, irq_o}, 1);
    wr(EN_A, 0);
    check("R6 irq after disable", {31'b0, irq_o}, 0);
    wr(PD_A, 32'hFFFF_FFFF);

    wr(EN_A, 32'h1234_5678);
    pulse(32'h0000_00F0);
    wr(16'h4801, 32'hFFFF_FFFF); wr(16'h4803, 32'hFFFF_FFFF);
    wr(16'h0800, 32'hFFFF_FFFF); wr(16'h5002, 32'hFFFF_FFFF);
    wr(16'h4000, 32'hFFFF_FFFF);
    rd(EN_A, v); check("R7 enable untouched", v, 32'h1234_5678);
    rd(PD_A, v); check("R7 pending untouched", v, 32'h0000_00F0);
    rd(16'h4801, v); check("R7 unmapped read", v, 0);
    rd(16'h5000, v); check("R7 other group read", v, 0);

    @(negedge clk); acc_addr = EN_A; acc_en = 0; #1 check("R8 idle rdata", acc_rdata, 0);
    acc_en = 1; acc_we = 1; acc_wdata = 32'h1234_5678;
    #1 check("R8 write-cycle rdata", acc_rdata, 0);
    @(negedge clk); acc_en = 0; acc_we = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule